// File: doc/BRIEF.md
# Serial Transmit Pin Ownership Controller

This block decides who drives one bidirectional port pin that is shared between general-purpose I/O and the data output of an asynchronous serial transmitter. It stores a direction bit and an output latch, both written through a simple CPU register interface. It takes an enable bit and a busy status from the serial core, and it produces an explicit output-enable and output-value pair for the pad. It also returns the value seen on a read of the port data register and a read-back of the direction bit.

While the transmitter is enabled or still shifting, the pin is forced to drive the serial data. Clearing the enable bit does not cut a character short, because a registered "transmitter active" flag holds ownership until the serial core reports that it is idle. Once ownership lapses, the pin returns to what the stored direction bit and latch select: either a high-impedance input or a driven copy of the latch.

Top module: `pin_tx_owner_top`

## Requirements
- R1: After reset the direction bit and latch are 0 and the transmitter-active flag is low, so `pin_oe` is 0, `rd_dir` is 0 and `rd_data` follows `pin_in`.
- R2: While `tx_enable` is 1, `pin_oe` is 1 and `pin_out` equals `tx_serial` in the same cycle, whatever the direction bit holds.
- R3: While `tx_busy` is 1, `pin_oe` is 1 and `pin_out` equals `tx_serial`, even with `tx_enable` at 0.
- R4: The transmitter-active flag is set at any rising edge where `tx_enable` or `tx_busy` is 1 and clears at the first rising edge where both are 0; until that edge the pin stays owned by the transmitter.
- R5: With ownership released and the direction bit 0, `pin_oe` is 0 (high-impedance input).
- R6: With ownership released and the direction bit 1, `pin_oe` is 1 and `pin_out` equals the latch, for latch values 0 and 1.
- R7: `rd_data` returns `pin_in` when the direction bit is 0 and the latch when it is 1, independent of ownership.
- R8: A latch write while the transmitter owns the pin updates the latch (seen on `rd_data` with direction 1) but `pin_out` keeps carrying `tx_serial` until release.
- R9: A write strobe loads the direction bit or latch at the next rising edge; `rd_dir` shows the stored direction bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_dir_en | input | 1 | Write strobe for the direction bit |
| wr_dir_val | input | 1 | Direction value to store (1 = output) |
| wr_lat_en | input | 1 | Write strobe for the output latch |
| wr_lat_val | input | 1 | Latch value to store |
| tx_enable | input | 1 | Transmitter enable bit from the serial core |
| tx_busy | input | 1 | Serial core is shifting a character |
| tx_serial | input | 1 | Serial data bit from the transmitter |
| pin_in | input | 1 | Level sensed at the pad |
| pin_oe | output | 1 | Pad output enable |
| pin_out | output | 1 | Pad output value |
| rd_data | output | 1 | Port data read value |
| rd_dir | output | 1 | Direction bit read value |

## Verification
The assertions assume the serial core only drops `tx_busy` once a character is complete and that `tx_enable`, `tx_busy` and the write strobes are stable around the rising edge. The bench drives every input on the falling edge and samples one time unit later, so each registered change is observed one full edge after its stimulus. Ownership release is exercised both with the direction bit at 0 and at 1, with the latch deliberately set to the opposite of the serial data so that a wrong multiplexer choice is visible on `pin_out`.

// File: rtl/pin_tx_pkg.sv
package pin_tx_pkg;

  typedef enum logic {
    OWN_PORT = 1'b0,
    OWN_TX   = 1'b1
  } owner_e;

  // pad enable: transmitter forces output, else direction bit rules
  function automatic logic f_pin_oe(input owner_e own, input logic dir);
    return (own == OWN_TX) | dir;
  endfunction

  // pad value: serial data while owned, else latch
  function automatic logic f_pin_val(input owner_e own, input logic ser,
                                     input logic lat);
    return (own == OWN_TX) ? ser : lat;
  endfunction

  // port read: latch when output, live pin when input
  function automatic logic f_port_read(input logic dir, input logic lat,
                                       input logic pin);
    return dir ? lat : pin;
  endfunction

endpackage

// File: rtl/pin_port_regs.sv
module pin_port_regs #(
  parameter logic RESET_DIR = 1'b0,
  parameter logic RESET_LAT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_dir_en,
  input  logic wr_dir_val,
  input  logic wr_lat_en,
  input  logic wr_lat_val,
  output logic dir_q,
  output logic lat_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= RESET_DIR;
    end else if (wr_dir_en) begin
      dir_q <= wr_dir_val;
    end
  end

  // latch accepts writes regardless of who owns the pin
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= RESET_LAT;
    end else if (wr_lat_en) begin
      lat_q <= wr_lat_val;
    end
  end

endmodule

// File: rtl/pin_tx_tracker.sv
module pin_tx_tracker
  import pin_tx_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tx_enable,
  input  logic   tx_busy,
  output logic   active_q,
  output owner_e owner
);

  logic want_pin;

  assign want_pin = tx_enable | tx_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
    end else begin
      active_q <= want_pin;
    end
  end

  // immediate take-over, release only after the registered flag drops
  assign owner = (want_pin | active_q) ? OWN_TX : OWN_PORT;

endmodule

// File: rtl/pin_tx_mux.sv
module pin_tx_mux
  import pin_tx_pkg::*;
(
  input  owner_e owner,
  input  logic   dir_q,
  input  logic   lat_q,
  input  logic   tx_serial,
  input  logic   pin_in,
  output logic   pin_oe,
  output logic   pin_out,
  output logic   rd_data
);

  always_comb begin
    pin_oe  = f_pin_oe(owner, dir_q);
    pin_out = f_pin_val(owner, tx_serial, lat_q);
    rd_data = f_port_read(dir_q, lat_q, pin_in);
  end

endmodule

// File: rtl/pin_tx_owner_top.sv
module pin_tx_owner_top
  import pin_tx_pkg::*;
#(
  parameter logic RESET_DIR = 1'b0,
  parameter logic RESET_LAT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_dir_en,
  input  logic wr_dir_val,
  input  logic wr_lat_en,
  input  logic wr_lat_val,
  input  logic tx_enable,
  input  logic tx_busy,
  input  logic tx_serial,
  input  logic pin_in,
  output logic pin_oe,
  output logic pin_out,
  output logic rd_data,
  output logic rd_dir
);

  logic   dir_q;
  logic   lat_q;
  logic   tx_active_q;
  owner_e owner;

  pin_port_regs #(
    .RESET_DIR (RESET_DIR),
    .RESET_LAT (RESET_LAT)
  ) regs_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_dir_en  (wr_dir_en),
    .wr_dir_val (wr_dir_val),
    .wr_lat_en  (wr_lat_en),
    .wr_lat_val (wr_lat_val),
    .dir_q      (dir_q),
    .lat_q      (lat_q)
  );

  pin_tx_tracker trk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_enable (tx_enable),
    .tx_busy   (tx_busy),
    .active_q  (tx_active_q),
    .owner     (owner)
  );

  pin_tx_mux mux_i (
    .owner     (owner),
    .dir_q     (dir_q),
    .lat_q     (lat_q),
    .tx_serial (tx_serial),
    .pin_in    (pin_in),
    .pin_oe    (pin_oe),
    .pin_out   (pin_out),
    .rd_data   (rd_data)
  );

  assign rd_dir = dir_q;

endmodule

// File: rtl/pin_tx_owner_chk.sv
module pin_tx_owner_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_enable,
  input logic tx_busy,
  input logic tx_serial,
  input logic pin_in,
  input logic pin_oe,
  input logic pin_out,
  input logic rd_data,
  input logic rd_dir,
  input logic tx_active_q,
  input logic lat_q,
  input logic wr_dir_en,
  input logic wr_dir_val
);

  // R2
  enable_forces_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_enable |-> (pin_oe && pin_out == tx_serial));

  // R3
  busy_forces_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |-> (pin_oe && pin_out == tx_serial));

  // R4
  active_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_enable || tx_busy) |=> tx_active_q);

  // R4
  active_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_enable && !tx_busy) |=> !tx_active_q);

  // R5
  released_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_active_q && !tx_enable && !tx_busy && !rd_dir) |-> !pin_oe);

  // R6
  released_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_active_q && !tx_enable && !tx_busy && rd_dir) |-> (pin_oe && pin_out == lat_q));

  // R7
  read_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_dir |-> (rd_data == pin_in));

  // R8
  owned_serial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_active_q |-> (pin_oe && pin_out == tx_serial));

  // R9
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir_en |=> (rd_dir == $past(wr_dir_val)));

endmodule

bind pin_tx_owner_top pin_tx_owner_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .tx_enable   (tx_enable),
  .tx_busy     (tx_busy),
  .tx_serial   (tx_serial),
  .pin_in      (pin_in),
  .pin_oe      (pin_oe),
  .pin_out     (pin_out),
  .rd_data     (rd_data),
  .rd_dir      (rd_dir),
  .tx_active_q (tx_active_q),
  .lat_q       (lat_q),
  .wr_dir_en   (wr_dir_en),
  .wr_dir_val  (wr_dir_val)
);

// File: tb/pin_tx_owner_top_tb_top.sv
`timescale 1ns/1ps
module pin_tx_owner_top_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_dir_en = 1'b0, wr_dir_val = 1'b0;
  logic wr_lat_en = 1'b0, wr_lat_val = 1'b0;
  logic tx_enable = 1'b0, tx_busy = 1'b0, tx_serial = 1'b0, pin_in = 1'b0;
  logic pin_oe, pin_out, rd_data, rd_dir;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pin_tx_owner_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_dir_en(wr_dir_en), .wr_dir_val(wr_dir_val),
    .wr_lat_en(wr_lat_en), .wr_lat_val(wr_lat_val),
    .tx_enable(tx_enable), .tx_busy(tx_busy), .tx_serial(tx_serial),
    .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out),
    .rd_data(rd_data), .rd_dir(rd_dir)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // drive at falling edge, look 1 ns later
  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic write_dir(input logic v);
    @(negedge clk);
    wr_dir_en = 1'b1; wr_dir_val = v;
    @(negedge clk);
    wr_dir_en = 1'b0;
    #1;
  endtask

  task automatic write_lat(input logic v);
    @(negedge clk);
    wr_lat_en = 1'b1; wr_lat_val = v;
    @(negedge clk);
    wr_lat_en = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    pin_in = 1'b1; #1;
    chk("R1 oe after reset", pin_oe, 1'b0);
    chk("R1 dir after reset", rd_dir, 1'b0);
    chk("R1 read follows pin 1", rd_data, 1'b1);
    pin_in = 1'b0; #1;
    chk("R1 read follows pin 0", rd_data, 1'b0);
  endtask

  task automatic t_port_mode();
    write_dir(1'b1);
    chk("R9 dir stored", rd_dir, 1'b1);
    write_lat(1'b1);
    chk("R6 oe dir1", pin_oe, 1'b1);
    chk("R6 out latch 1", pin_out, 1'b1);
    pin_in = 1'b0; #1;
    chk("R7 read latch 1", rd_data, 1'b1);
    write_lat(1'b0);
    chk("R6 out latch 0", pin_out, 1'b0);
    pin_in = 1'b1; #1;
    chk("R7 read latch 0", rd_data, 1'b0);
  endtask

  task automatic t_enable_forces();
    write_dir(1'b0);
    chk("R5 idle input", pin_oe, 1'b0);
    @(negedge clk);
    tx_enable = 1'b1; tx_serial = 1'b1; #1;
    chk("R2 oe with enable", pin_oe, 1'b1);
    chk("R2 out serial 1", pin_out, 1'b1);
    tx_serial = 1'b0; #1;
    chk("R2 out serial 0", pin_out, 1'b0);
    pin_in = 1'b1; #1;
    chk("R7 read live while owned", rd_data, 1'b1);
    @(negedge clk);
    tx_enable = 1'b0; #1;
    chk("R4 still owned until edge", pin_oe, 1'b1);
    settle();
    chk("R5 released to input", pin_oe, 1'b0);
  endtask

  task automatic t_busy_hold();
    write_dir(1'b1);
    write_lat(1'b1);
    @(negedge clk);
    tx_enable = 1'b1; tx_serial = 1'b0; #1;
    chk("R2 serial over latch", pin_out, 1'b0);
    @(negedge clk);
    tx_enable = 1'b0; tx_busy = 1'b1; #1;
    chk("R3 busy keeps oe", pin_oe, 1'b1);
    chk("R3 busy keeps serial", pin_out, 1'b0);
    // latch write during ownership
    write_lat(1'b0);
    tx_serial = 1'b1; #1;
    chk("R8 latch updated", rd_data, 1'b0);
    chk("R8 pin keeps serial", pin_out, 1'b1);
    @(negedge clk);
    tx_busy = 1'b0; #1;
    chk("R4 owned until edge", pin_out, 1'b1);
    settle();
    chk("R6 released oe", pin_oe, 1'b1);
    chk("R6 released drives latch", pin_out, 1'b0);
    chk("R4 serial ignored after release", pin_out, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_port_mode();
    t_enable_forces();
    t_busy_hold();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule